// File: doc/BRIEF.md
# Byte-at-a-time SPI master with register access

This block is a host-programmed SPI master that moves exactly one byte per command over a half-duplex link. A processor writes a configuration word and a data byte through a simple register port, then issues either a send command or a receive command. The block produces the serial clock, shifts the byte out on MOSI or collects eight bits from MISO, and reports a busy flag until the byte is done. Chip select is not sequenced by hardware: it follows a control bit that software sets and clears around the transfers it wants to group.

Timing is fully selectable. Software picks the bit order, the idle level of the serial clock, which clock edge (rising or falling) launches MOSI and, on its own, which edge samples MISO. The serial clock is the system clock divided by a power of two, and one divider setting stops the clock altogether, so a pending transfer simply waits. Each pin has an output-enable so the pins can be handed to another master.

Top module: `spi_byte_master`

## Requirements
- R1: Registers are decoded on the byte address: 0x00 status (bit 0 busy), 0x10 configuration, 0x14 control, 0x20 data (only bits 7:0 stored, upper read bits zero). After reset configuration reads 0, control reads 0x1 and data reads 0; unused configuration bits (7, 31:9) read as zero.
- R2: Configuration bit 8 set sends and receives the most significant bit first; clear sends and receives the least significant bit first.
- R3: Configuration bit 6 is the serial clock idle level; SCK sits at this level whenever no transfer is in progress.
- R4: Configuration bit 5 set samples MISO on falling SCK edges (clear: rising); configuration bit 4 set launches MOSI on falling edges (clear: rising), each chosen independently. The first bit is on MOSI from the start command, and the MOSI value just before each of the eight sampling edges is the byte's next bit in the selected order.
- R5: Configuration bits 2:0 hold code c; for c from 0 to 6 each SCK half-period lasts 2^c system clocks. Every transfer makes 16 SCK edges, so busy stays set for exactly 16·2^c cycles and the last edge returns SCK to its idle level.
- R6: With code 7 a transfer in progress does not advance and SCK holds its level; writing another code resumes it.
- R7: Busy reads 1 in the cycle after a start is written. Control bit 2 starts a send, control bit 1 starts a receive (bit 2 wins if both are set). Start bits written while busy has no effect on the running byte and launch no second transfer.
- R8: A receive holds MOSI at 0 and, when busy clears, places the eight sampled MISO bits in the data register; if software writes the data register on that same cycle, the received byte wins.
- R9: A send ignores MISO and leaves the data register as software last wrote it.
- R10: Control bit 0 is the chip-select output level (1 high, 0 low).
- R11: Configuration bit 3 set releases all outputs (SCK, MOSI, CS enables low); control bit 3 set releases MOSI alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | MOSI output enable |
| cs_o | output | 1 | Chip-select level |
| cs_oe | output | 1 | Chip-select output enable |
| miso_i | input | 1 | Serial data from the slave |

## Verification
The end of a receive and a software write to the data register can land on the same clock edge, since busy clearing and the load of the sampled byte happen together. The bench counts cycles from the start command at the fastest divider setting and times a data-register write to that exact edge, then reads the register back and expects the byte the slave model supplied rather than the value software wrote. A second overlap, start commands and data writes issued while a send is still shifting, is judged by the busy duration and by the scoreboard seeing one byte and only one.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
   localparam int ADDR_W = 8;
   localparam logic [ADDR_W-1:0] OFS_STAT = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_DATA = 8'h20;

   // configuration field positions
   localparam int CF_MSB   = 8;
   localparam int CF_IDLE  = 6;
   localparam int CF_CAPF  = 5;
   localparam int CF_TXF   = 4;
   localparam int CF_HIZ   = 3;
   // control field positions
   localparam int CT_MHIZ  = 3;
   localparam int CT_SEND  = 2;
   localparam int CT_RECV  = 1;
   localparam int CT_CS    = 0;

   typedef struct packed {
      logic msb_first;
      logic idle_hi;
      logic cap_fall;
      logic tx_fall;
      logic pins_hiz;
   } cfg_flags_t;
endpackage

// File: rtl/spi_bm_regs.sv
`timescale 1ns/1ps
module spi_bm_regs
   import spi_bm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CODE_W = 3,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              busy,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_byte,
   output logic [REG_W-1:0]  rdata,
   output cfg_flags_t        flags,
   output logic [CODE_W-1:0] div_code,
   output logic              cs_level,
   output logic              mosi_hiz,
   output logic [DATA_W-1:0] tx_byte,
   output logic              start_req,
   output logic              start_wr,
   output logic              start_rd
);
   if (REG_W < CF_MSB + 1) begin : g_bad_regw
      $error("REG_W too narrow for the configuration word");
   end
   if (DATA_W > REG_W) begin : g_bad_dataw
      $error("DATA_W wider than the register port");
   end

   logic wr_cfg, wr_ctl, wr_data;
   assign wr_cfg  = wr_en && (addr == OFS_CFG);
   assign wr_ctl  = wr_en && (addr == OFS_CTL);
   assign wr_data = wr_en && (addr == OFS_DATA);

   assign start_req = wr_ctl && (wdata[CT_SEND] || wdata[CT_RECV]);
   assign start_wr  = start_req && !busy && wdata[CT_SEND];
   assign start_rd  = start_req && !busy && !wdata[CT_SEND];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         div_code <= '0;
         cs_level <= 1'b1;
         mosi_hiz <= 1'b0;
         tx_byte  <= '0;
      end else begin
         if (wr_cfg) begin
            flags.msb_first <= wdata[CF_MSB];
            flags.idle_hi   <= wdata[CF_IDLE];
            flags.cap_fall  <= wdata[CF_CAPF];
            flags.tx_fall   <= wdata[CF_TXF];
            flags.pins_hiz  <= wdata[CF_HIZ];
            div_code        <= wdata[CODE_W-1:0];
         end
         if (wr_ctl) begin
            cs_level <= wdata[CT_CS];
            mosi_hiz <= wdata[CT_MHIZ];
         end
         // a finishing receive takes priority over a software write
         if (load_en)      tx_byte <= load_byte;
         else if (wr_data) tx_byte <= wdata[DATA_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         OFS_STAT: rdata[0] = busy;
         OFS_CFG: begin
            rdata[CF_MSB]       = flags.msb_first;
            rdata[CF_IDLE]      = flags.idle_hi;
            rdata[CF_CAPF]      = flags.cap_fall;
            rdata[CF_TXF]       = flags.tx_fall;
            rdata[CF_HIZ]       = flags.pins_hiz;
            rdata[CODE_W-1:0]   = div_code;
         end
         OFS_CTL: begin
            rdata[CT_MHIZ] = mosi_hiz;
            rdata[CT_CS]   = cs_level;
         end
         OFS_DATA: rdata[DATA_W-1:0] = tx_byte;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_bm_clkdiv.sv
`timescale 1ns/1ps
module spi_bm_clkdiv #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int NCODE = 1 << CODE_W;
   localparam int NRUN  = NCODE - 1;      // last code stops the clock
   localparam int CNT_W = NCODE - 2;      // holds the longest half-period

   if (CODE_W < 2 || CODE_W > 4) begin : g_bad_code
      $error("CODE_W must lie in 2..4");
   end

   logic [CNT_W-1:0] cnt;
   logic [NRUN-1:0]  hit;

   for (genvar i = 0; i < NRUN; i++) begin : g_hit
      assign hit[i] = (code == CODE_W'(i)) && (cnt == CNT_W'((1 << i) - 1));
   end

   assign tick = run && (|hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (!run || tick)          cnt <= '0;
      else if (code != '1)            cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_bm_shift.sv
`timescale 1ns/1ps
module spi_bm_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_wr,
   input  logic              start_rd,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              msb_first,
   input  logic              idle_hi,
   input  logic              cap_fall,
   input  logic              tx_fall,
   input  logic              miso_i,
   output logic              busy,
   output logic              sck_q,
   output logic              mosi_bit,
   output logic              rd_mode,
   output logic              load_en,
   output logic [DATA_W-1:0] load_byte
);
   localparam int EDGES = 2 * DATA_W;
   localparam int EC_W  = $clog2(EDGES);
   localparam int SC_W  = $clog2(DATA_W + 1);

   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end

   logic [EC_W-1:0]   edge_cnt;
   logic [SC_W-1:0]   smp_cnt;
   logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
   logic              sck_next, is_smp, is_lch, last;

   assign sck_next = ~sck_q;
   assign is_smp   = ((sck_next ^ cap_fall) == 1'b1) && (smp_cnt < SC_W'(DATA_W));
   // no launch before the first bit has been sampled
   assign is_lch   = ((sck_next ^ tx_fall) == 1'b1) && ((smp_cnt != '0) || is_smp);
   assign last     = (edge_cnt == EC_W'(EDGES - 1));
   assign rx_next  = msb_first ? {rx_sh[DATA_W-2:0], miso_i}
                               : {miso_i, rx_sh[DATA_W-1:1]};
   assign mosi_bit = msb_first ? tx_sh[DATA_W-1] : tx_sh[0];
   assign load_en  = busy && tick && last && rd_mode;
   assign load_byte = is_smp ? rx_next : rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sck_q    <= 1'b0;
         rd_mode  <= 1'b0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         edge_cnt <= '0;
         smp_cnt  <= '0;
      end else if (start_wr || start_rd) begin
         busy     <= 1'b1;
         rd_mode  <= start_rd;
         tx_sh    <= tx_byte;
         rx_sh    <= '0;
         edge_cnt <= '0;
         smp_cnt  <= '0;
         sck_q    <= idle_hi;
      end else if (busy && tick) begin
         sck_q    <= sck_next;
         edge_cnt <= edge_cnt + 1'b1;
         if (is_smp) begin
            rx_sh   <= rx_next;
            smp_cnt <= smp_cnt + 1'b1;
         end
         if (is_lch)
            tx_sh <= msb_first ? {tx_sh[DATA_W-2:0], 1'b0} : {1'b0, tx_sh[DATA_W-1:1]};
         if (last) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
   import spi_bm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CODE_W = 3,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              sck_o,
   output logic              sck_oe,
   output logic              mosi_o,
   output logic              mosi_oe,
   output logic              cs_o,
   output logic              cs_oe,
   input  logic              miso_i
);
   cfg_flags_t        flags;
   logic [CODE_W-1:0] div_code;
   logic              cs_level, mosi_hiz;
   logic [DATA_W-1:0] tx_byte, load_byte;
   logic              start_req, start_wr, start_rd, start_any;
   logic              busy, sck_q, mosi_bit, rd_mode, load_en, tick;
   logic              idle_hi_w, pins_hiz_w;

   assign start_any  = start_wr || start_rd;
   assign idle_hi_w  = flags.idle_hi;
   assign pins_hiz_w = flags.pins_hiz;

   spi_bm_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .REG_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .busy      (busy),
      .load_en   (load_en),
      .load_byte (load_byte),
      .rdata     (reg_rdata),
      .flags     (flags),
      .div_code  (div_code),
      .cs_level  (cs_level),
      .mosi_hiz  (mosi_hiz),
      .tx_byte   (tx_byte),
      .start_req (start_req),
      .start_wr  (start_wr),
      .start_rd  (start_rd)
   );

   spi_bm_clkdiv #(.CODE_W(CODE_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .code  (div_code),
      .tick  (tick)
   );

   spi_bm_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start_wr  (start_wr),
      .start_rd  (start_rd),
      .tx_byte   (tx_byte),
      .msb_first (flags.msb_first),
      .idle_hi   (flags.idle_hi),
      .cap_fall  (flags.cap_fall),
      .tx_fall   (flags.tx_fall),
      .miso_i    (miso_i),
      .busy      (busy),
      .sck_q     (sck_q),
      .mosi_bit  (mosi_bit),
      .rd_mode   (rd_mode),
      .load_en   (load_en),
      .load_byte (load_byte)
   );

   assign sck_o   = busy ? sck_q : flags.idle_hi;
   assign sck_oe  = !flags.pins_hiz;
   assign mosi_o  = (busy && !rd_mode) ? mosi_bit : 1'b0;
   assign mosi_oe = !flags.pins_hiz && !mosi_hiz;
   assign cs_o    = cs_level;
   assign cs_oe   = !flags.pins_hiz;
endmodule

// File: rtl/spi_byte_master_chk.sv
`timescale 1ns/1ps
module spi_byte_master_chk #(
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              start_any,
   input logic              sck_o,
   input logic              idle_hi,
   input logic [CODE_W-1:0] div_code,
   input logic              rd_mode,
   input logic              mosi_o,
   input logic              pins_hiz,
   input logic              sck_oe,
   input logic              mosi_oe,
   input logic              cs_oe
);
   assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_any |=> busy);

   assert_busy_only_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_any));

   assert_frozen_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (div_code == '1)) |=> $stable(sck_o));

   assert_final_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $stable(idle_hi)) |-> (sck_o != $past(sck_o)));

   assert_recv_mosi_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_mode) |-> (mosi_o == 1'b0));

   assert_pins_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pins_hiz |-> (!sck_oe && !mosi_oe && !cs_oe));
endmodule

bind spi_byte_master spi_byte_master_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .start_any (start_any),
   .sck_o     (sck_o),
   .idle_hi   (idle_hi_w),
   .div_code  (div_code),
   .rd_mode   (rd_mode),
   .mosi_o    (mosi_o),
   .pins_hiz  (pins_hiz_w),
   .sck_oe    (sck_oe),
   .mosi_oe   (mosi_oe),
   .cs_oe     (cs_oe)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
   localparam logic [7:0] A_STAT = 8'h00, A_CFG = 8'h10, A_CTL = 8'h14, A_DATA = 8'h20;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sck_o, sck_oe, mosi_o, mosi_oe, cs_o, cs_oe;
   logic        miso = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   spi_byte_master dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .cs_o(cs_o), .cs_oe(cs_oe), .miso_i(miso)
   );

   int checks = 0, errors = 0;
   int cyc = 0, c_start = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // scoreboard state
   logic [7:0] exp_q[$];
   bit         mon_on = 0;
   int         mon_k = 0;
   logic [7:0] got = '0;
   logic       m_capf = 0, m_msb = 1;
   logic [7:0] slave_v = '0;
   logic       last_sck = 0, last_mosi = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic slave_bit(input int k);
      if (k > 7) return 1'b0;
      return m_msb ? slave_v[7-k] : slave_v[k];
   endfunction

   // monitor: capture MOSI just before each master sampling edge, feed MISO after it
   always @(negedge clk) begin
      if (mon_on && (sck_o !== last_sck) && ((sck_o ^ m_capf) == 1'b1)) begin
         got[mon_k] = last_mosi;
         mon_k++;
         miso = slave_bit(mon_k);
         if (mon_k == 8) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R4", "MOSI bit sequence at sampling edges", int'(got), int'(e));
            mon_on = 0;
         end
      end
      last_sck  = sck_o;
      last_mosi = mosi_o;
   end

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output int n);
      reg_addr = A_STAT;
      #1;
      while (reg_rdata[0]) begin
         @(negedge clk);
         #1;
      end
      n = cyc - c_start;
   endtask

   function automatic logic [8:0] cfgw(input logic msb, pol, capf, txf, input int code);
      return {msb, 1'b0, pol, capf, txf, 1'b0, 3'(code)};
   endfunction

   // driver: programs the block, pushes the expected bit sequence, starts
   task automatic launch(input bit rd, input logic [7:0] d, input logic msb, pol, capf, txf,
                         input int code, input logic [7:0] sv, input logic [7:0] ctl_extra);
      logic [7:0] seq;
      reg_write(A_CFG, 32'(cfgw(msb, pol, capf, txf, code)));
      if (!rd) reg_write(A_DATA, 32'(d));
      for (int k = 0; k < 8; k++) seq[k] = msb ? d[7-k] : d[k];   // R2 bit order
      exp_q.push_back(rd ? 8'h00 : seq);
      slave_v = sv; m_msb = msb; m_capf = capf; mon_k = 0;
      miso = slave_bit(0);
      mon_on = 1;
      reg_write(A_CTL, 32'((rd ? 8'h02 : 8'h04) | ctl_extra));
      c_start = cyc;
      reg_addr = A_STAT;
      #1 chk("R7", "busy in cycle after start", int'(reg_rdata[0]), 1);
   endtask

   task automatic run_xfer(input bit rd, input logic [7:0] d, input logic msb, pol, capf, txf,
                           input int code, input logic [7:0] sv);
      int n;
      logic [31:0] v;
      launch(rd, d, msb, pol, capf, txf, code, sv, 8'h00);
      wait_idle(n);
      chk("R5", "busy duration", n, 16 << code);
      chk("R4", "all eight sampling edges seen", int'(mon_on), 0);
      chk("R3", "SCK back at idle level", int'(sck_o), int'(pol));
      reg_read(A_DATA, v);
      if (rd) chk("R8", "received byte in data register", int'(v), int'(sv));
      else    chk("R9", "data register kept after send", int'(v), int'(d));
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values and map
      reg_read(A_CFG, v);  chk("R1", "cfg reset", int'(v), 0);
      reg_read(A_CTL, v);  chk("R1", "ctl reset", int'(v), 1);
      reg_read(A_STAT, v); chk("R1", "status reset", int'(v), 0);
      reg_read(A_DATA, v); chk("R1", "data reset", int'(v), 0);
      chk("R3", "SCK idle after reset", int'(sck_o), 0);
      chk("R10", "CS high after reset", int'(cs_o), 1);
      chk("R11", "outputs enabled after reset", int'({sck_oe, mosi_oe, cs_oe}), 7);

      reg_write(A_CFG, 32'hFFFF_FFFF);
      reg_read(A_CFG, v);  chk("R1", "cfg readback masks unused bits", int'(v), 32'h17F);
      reg_write(A_DATA, 32'h0000_1234);
      reg_read(A_DATA, v); chk("R1", "data keeps low byte", int'(v), 32'h34);
      reg_write(A_CFG, 32'h0);

      // R10 chip select
      reg_write(A_CTL, 32'h0); #1 chk("R10", "CS low", int'(cs_o), 0);
      reg_write(A_CTL, 32'h1); #1 chk("R10", "CS high", int'(cs_o), 1);
      reg_write(A_CTL, 32'h0);

      // R2 R4 R5 sends over edge/order/divider combinations; MISO toggles and is ignored (R9)
      run_xfer(0, 8'hA3, 1, 0, 0, 1, 0, 8'hFF);
      run_xfer(0, 8'h5C, 0, 0, 1, 0, 1, 8'h55);
      run_xfer(0, 8'h96, 1, 1, 1, 0, 2, 8'h0F);
      run_xfer(0, 8'h3E, 1, 1, 0, 0, 0, 8'hAA);
      run_xfer(0, 8'hC1, 0, 0, 0, 0, 3, 8'h33);
      // R8 receives
      run_xfer(1, 8'h00, 1, 0, 0, 1, 0, 8'hA5);
      run_xfer(1, 8'h00, 0, 1, 1, 0, 1, 8'h4D);

      // R11 MOSI released alone during a receive
      launch(1, 8'h00, 1, 0, 0, 1, 1, 8'h69, 8'h08);
      chk("R11", "MOSI released by control bit 3", int'(mosi_oe), 0);
      chk("R11", "SCK still driven with control bit 3", int'(sck_oe), 1);
      wait_idle(n);
      reg_read(A_DATA, v); chk("R8", "receive with MOSI released", int'(v), 32'h69);
      reg_write(A_CTL, 32'h0);

      // R7 starts during busy are ignored; data write during send is kept (R9)
      launch(0, 8'h6B, 1, 0, 0, 1, 1, 8'h00, 8'h00);
      reg_write(A_CTL, 32'h4);
      reg_write(A_DATA, 32'h11);
      reg_write(A_CTL, 32'h2);
      wait_idle(n);
      chk("R7", "single transfer despite extra starts", n, 32);
      repeat (20) @(negedge clk);
      reg_read(A_STAT, v); chk("R7", "no second transfer launched", int'(v), 0);
      chk("R7", "no extra bits on the wire", int'(mon_on), 0);
      reg_read(A_DATA, v); chk("R9", "software data write during send kept", int'(v), 32'h11);

      // R6 divider code 7 stops the transfer
      launch(0, 8'h81, 1, 0, 0, 1, 7, 8'h00, 8'h00);
      repeat (100) @(negedge clk);
      chk("R6", "SCK held at idle with code 7", int'(sck_o), 0);
      reg_read(A_STAT, v); chk("R6", "still busy with code 7", int'(v), 1);
      chk("R6", "no bit sampled with code 7", mon_k, 0);
      reg_write(A_CFG, 32'(cfgw(1, 0, 0, 1, 0)));
      wait_idle(n);
      chk("R6", "transfer resumes after code change", int'(mon_on), 0);

      // R8 collision: software data write on the completion edge of a receive
      launch(1, 8'h00, 1, 0, 0, 1, 0, 8'hA5, 8'h00);
      repeat (14) @(negedge clk);
      reg_write(A_DATA, 32'h3C);
      reg_read(A_STAT, v); chk("R8", "receive finished on collision edge", int'(v), 0);
      reg_read(A_DATA, v); chk("R8", "received byte wins over same-cycle write", int'(v), 32'hA5);

      // R11 configuration releases every pin
      reg_write(A_CFG, 32'h8);
      #1 chk("R11", "all pins released", int'({sck_oe, mosi_oe, cs_oe}), 0);
      reg_write(A_CFG, 32'h0);
      #1 chk("R11", "pins driven again", int'({sck_oe, mosi_oe, cs_oe}), 7);

      // R3 idle level follows configuration
      reg_write(A_CFG, 32'h40);
      #1 chk("R3", "SCK idles high", int'(sck_o), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule